// File: doc/BRIEF.md
# DES Key-Schedule and Data State Unit

This block holds the working state for software-driven DES and Triple-DES next to a 32-bit RISC datapath. The state is a 64-bit data word and a 56-bit key kept as two 28-bit halves, C and D. Four single-cycle custom operations act on this state. The opcode and two 32-bit source operands come from the general-purpose register file, and the 32-bit result goes back to it.

Software loads a key and a data block, then issues one step per round. Each step rotates both key halves and presents the 48-bit round subkey on a dedicated output for the round-function hardware. Software reads the data word back in two halves. The block has no round counter or pass sequencer; the instruction stream supplies all sequencing. Direction and shift count are chosen per step by operand bits.

Top module: `des_state_unit`

## Requirements
- R1: Reset clears C, D and the data word. After reset, reads of either data half return zero, and a decrypt step presents a zero subkey.
- R2: Opcode 3'd1 (key load) sets C to opA[27:0] and D to opB[27:0] at the next edge. Operand bits [31:28] have no effect.
- R3: Opcode 3'd2 (data store) writes opA into data bits [63:32] and opB into bits [31:0] at the next edge.
- R4: Opcode 3'd3 (data read) drives `result` in the same cycle with data[63:32] when opA[0]=1 and with data[31:0] when opA[0]=0.
- R5: Opcode 3'd4 (step) with opA[1]=0 (encrypt) rotates C and D left. The rotation is one position when opA[0]=0 and two positions when opA[0]=1. The subkey shown in that cycle is taken from the rotated halves.
- R6: A step with opA[1]=1 (decrypt) rotates C and D right by the same 1-or-2 rule. The subkey shown in that cycle is taken from the halves before rotation.
- R7: The subkey is the standard DES permuted-choice-2 selection of the 56-bit value {C, D}, with C in the upper 28 bits. Subkey bit 47 is the first selected bit.
- R8: Opcodes 3'd0, 3'd5, 3'd6 and 3'd7 leave C, D and the data word unchanged. For every opcode other than 3'd3, `result` is zero. For every opcode other than 3'd4, `subkey` is zero.
- R9: Every operation completes in one clock. An operation issued in the cycle right after another sees that operation's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opcode | input | 3 | Custom operation select |
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand |
| result | output | 32 | Value returned to the register file |
| subkey | output | 48 | Round subkey for the current step |

## Verification
A step updates the key halves and presents its subkey in the same cycle. The direction decides whether the subkey reflects the old or the new halves. The bench issues steps back to back in both directions and with both shift counts, including full 16-round encrypt schedules followed by the mirrored decrypt schedule. Each subkey is compared with one computed from a bench model of the rotations, and the decrypt pass must reproduce the encrypt subkeys in reverse order. Stores are also followed at once by reads, to confirm that the new data word is visible in the very next cycle.

// File: rtl/des_state_pkg.sv
package des_state_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 2 * WORD_W;
  localparam int HALF_W = 28;
  localparam int KEY_W  = 2 * HALF_W;
  localparam int SUB_W  = 48;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_KEYSET  = 3'd1;
  localparam logic [OP_W-1:0] OP_DATASET = 3'd2;
  localparam logic [OP_W-1:0] OP_DATAGET = 3'd3;
  localparam logic [OP_W-1:0] OP_STEP    = 3'd4;

  // Selection positions, 1-based from the MSB of {C, D}.
  localparam int PC2_SEL [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  typedef struct packed {
    logic keyWr;
    logic dataWr;
    logic readEn;
    logic readHi;
    logic stepEn;
    logic stepTwo;
    logic stepDec;
  } strobe_t;
endpackage

// File: rtl/des_state_ctrl.sv
module des_state_ctrl
  import des_state_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [WORD_W-1:0] opA,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    unique case (opcode)
      OP_KEYSET:  strobe.keyWr = 1'b1;
      OP_DATASET: strobe.dataWr = 1'b1;
      OP_DATAGET: begin
        strobe.readEn = 1'b1;
        strobe.readHi = opA[0];
      end
      OP_STEP: begin
        strobe.stepEn  = 1'b1;
        strobe.stepTwo = opA[0];
        strobe.stepDec = opA[1];
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/des_state_dp.sv
module des_state_dp
  import des_state_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic [SUB_W-1:0]  subkey,
  output logic [HALF_W-1:0] cState,
  output logic [HALF_W-1:0] dState,
  output logic [DATA_W-1:0] dataState
);
  logic [HALF_W-1:0] cReg, dReg, cRot, dRot;
  logic [DATA_W-1:0] dataReg;
  logic [KEY_W-1:0]  selSrc;
  logic [SUB_W-1:0]  selOut;

  function automatic logic [HALF_W-1:0] rotHalf(
    input logic [HALF_W-1:0] v, input logic dec, input logic two);
    logic [HALF_W-1:0] r;
    case ({dec, two})
      2'b00:   r = {v[HALF_W-2:0], v[HALF_W-1]};
      2'b01:   r = {v[HALF_W-3:0], v[HALF_W-1:HALF_W-2]};
      2'b10:   r = {v[0], v[HALF_W-1:1]};
      default: r = {v[1:0], v[HALF_W-1:2]};
    endcase
    return r;
  endfunction

  assign cRot = rotHalf(cReg, strobe.stepDec, strobe.stepTwo);
  assign dRot = rotHalf(dReg, strobe.stepDec, strobe.stepTwo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cReg    <= '0;
      dReg    <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.keyWr) begin
        cReg <= opA[HALF_W-1:0];
        dReg <= opB[HALF_W-1:0];
      end else if (strobe.stepEn) begin
        cReg <= cRot;
        dReg <= dRot;
      end
      if (strobe.dataWr) dataReg <= {opA, opB};
    end
  end

  // Decrypt selects before rotating; encrypt selects after.
  assign selSrc = strobe.stepDec ? {cReg, dReg} : {cRot, dRot};

  for (genvar g = 0; g < SUB_W; g++) begin : g_pc2
    assign selOut[SUB_W-1-g] = selSrc[KEY_W - PC2_SEL[g]];
  end

  assign subkey = strobe.stepEn ? selOut : '0;
  assign result = !strobe.readEn ? '0 :
                  (strobe.readHi ? dataReg[DATA_W-1:WORD_W] : dataReg[WORD_W-1:0]);

  assign cState    = cReg;
  assign dState    = dReg;
  assign dataState = dataReg;
endmodule

// File: rtl/des_state_unit.sv
module des_state_unit
  import des_state_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic [SUB_W-1:0]  subkey
);
  strobe_t           strobe;
  logic [HALF_W-1:0] cState, dState;
  logic [DATA_W-1:0] dataState;

  des_state_ctrl u_ctrl (
    .opcode (opcode),
    .opA    (opA),
    .strobe (strobe)
  );

  des_state_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .subkey    (subkey),
    .cState    (cState),
    .dState    (dState),
    .dataState (dataState)
  );
endmodule

// File: rtl/des_state_chk.sv
module des_state_chk
  import des_state_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [OP_W-1:0]   opcode,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic [WORD_W-1:0] result,
  input logic [SUB_W-1:0]  subkey,
  input logic [HALF_W-1:0] cState,
  input logic [HALF_W-1:0] dState,
  input logic [DATA_W-1:0] dataState
);
  logic isIdle;
  assign isIdle = (opcode == 3'd0) || (opcode > OP_STEP);

  AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_KEYSET) |=> (cState == $past(opA[HALF_W-1:0]) &&
                               dState == $past(opB[HALF_W-1:0]))); // R2

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_DATASET) |=> (dataState == $past({opA, opB}))); // R3

  AST_READ_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_DATAGET && opA[0]) |-> (result == dataState[DATA_W-1:WORD_W])); // R4

  AST_ENC_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_STEP && !opA[1] && !opA[0]) |=>
      (cState == {$past(cState[HALF_W-2:0]), $past(cState[HALF_W-1])})); // R5

  AST_DEC_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_STEP && opA[1] && opA[0]) |=>
      (dState == {$past(dState[1:0]), $past(dState[HALF_W-1:2])})); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |=> ($stable(cState) && $stable(dState) && $stable(dataState))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |-> (result == '0 && subkey == '0)); // R8
endmodule

bind des_state_unit des_state_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opcode    (opcode),
  .opA       (opA),
  .opB       (opB),
  .result    (result),
  .subkey    (subkey),
  .cState    (cState),
  .dState    (dState),
  .dataState (dataState)
);

// File: tb/tb_des_state_unit.sv
module tb_des_state_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opcode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] result;
  logic [47:0] subkey;

  int checks = 0;
  int fails = 0;
  logic [27:0] mC = '0, mD = '0;
  logic [63:0] mData = '0;
  logic [31:0] seed = 32'h1234_5678;
  logic [47:0] encKeys [16];
  int shiftSched [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};
  int pc2Tab [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                      41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  always #10 clk = ~clk;

  des_state_unit dut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .opA(opA), .opB(opB),
    .result(result), .subkey(subkey)
  );

  function automatic logic [27:0] mRot(input logic [27:0] v, input bit dec, input int n);
    logic [55:0] w;
    w = {v, v};
    if (!dec) return w[55 - n -: 28];
    return w[27 + n -: 28];
  endfunction

  function automatic logic [47:0] mPc2(input logic [27:0] c, input logic [27:0] d);
    logic [55:0] cd;
    logic [47:0] k;
    cd = {c, d};
    for (int i = 0; i < 48; i++) k[47 - i] = cd[56 - pc2Tab[i]];
    return k;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation; check same-cycle outputs; advance the model.
  task automatic doOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      output logic [47:0] keyOut);
    logic [31:0] expRes;
    logic [47:0] expKey;
    int n;
    bit dec;
    @(negedge clk);
    opcode = op; opA = a; opB = b;
    n = a[0] ? 2 : 1;
    dec = a[1];
    expRes = (op == 3'd3) ? (a[0] ? mData[63:32] : mData[31:0]) : 32'h0;
    if (op != 3'd4) expKey = '0;
    else if (dec) expKey = mPc2(mC, mD);
    else expKey = mPc2(mRot(mC, 1'b0, n), mRot(mD, 1'b0, n));
    #5;
    check((op == 3'd3) ? "R4 read result" : "R8 result zero", {32'h0, result}, {32'h0, expRes});
    check((op != 3'd4) ? "R8 subkey zero" : (dec ? "R6 decrypt subkey" : "R5 encrypt subkey"),
          {16'h0, subkey}, {16'h0, expKey});
    keyOut = subkey;
    case (op)
      3'd1: begin mC = a[27:0]; mD = b[27:0]; end
      3'd2: mData = {a, b};
      3'd4: begin mC = mRot(mC, dec, n); mD = mRot(mD, dec, n); end
      default: ;
    endcase
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] k;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state seen through reads and a decrypt step
    doOp(3'd3, 32'h1, 32'h0, k);
    check("R1 upper after reset", {32'h0, result}, 64'h0);
    doOp(3'd3, 32'h0, 32'h0, k);
    doOp(3'd4, 32'h2, 32'h0, k);
    check("R1 subkey after reset", {16'h0, k}, 64'h0);

    // R2 and R7: key load with junk upper bits, known schedule vectors
    doOp(3'd1, 32'hAF0C_CAAF, 32'h5556_678F, k);
    doOp(3'd4, 32'h0, 32'h0, k);
    check("R7 round one vector", {16'h0, k}, {16'h0, 48'h1B02EFFC7072});
    doOp(3'd4, 32'h0, 32'h0, k);
    check("R7 round two vector", {16'h0, k}, {16'h0, 48'h79AED9DBC9E5});

    // R3 and R9: store then read immediately
    doOp(3'd2, 32'hDEAD_BEEF, 32'h0123_4567, k);
    doOp(3'd3, 32'h1, 32'h0, k);
    check("R3 upper half", {32'h0, result}, {32'h0, 32'hDEAD_BEEF});
    doOp(3'd3, 32'h0, 32'h0, k);
    check("R3 lower half", {32'h0, result}, {32'h0, 32'h0123_4567});

    // R8: unrecognised opcodes hold state
    for (int op = 0; op < 8; op++) begin
      if (op >= 1 && op <= 4) continue;
      doOp(op[2:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF, k);
      doOp(3'd3, 32'h1, 32'h0, k);
      check("R8 data held", {32'h0, result}, {32'h0, 32'hDEAD_BEEF});
    end

    // R5/R6/R9: full schedules forward and mirrored back
    for (int it = 0; it < 40; it++) begin
      logic [31:0] ka, kb;
      seed = nextRand(seed); ka = seed;
      seed = nextRand(seed); kb = seed;
      doOp(3'd1, ka, kb, k);
      for (int r = 0; r < 16; r++) begin
        doOp(3'd4, (shiftSched[r] == 2) ? 32'h1 : 32'h0, 32'h0, k);
        encKeys[r] = k;
      end
      for (int j = 0; j < 16; j++) begin
        doOp(3'd4, (shiftSched[15 - j] == 2) ? 32'h3 : 32'h2, 32'h0, k);
        check("R6 reverse order", {16'h0, k}, {16'h0, encKeys[15 - j]});
      end
      doOp(3'd4, 32'h2, 32'h0, k);
      check("R9 key restored", {16'h0, k}, {16'h0, mPc2(ka[27:0], kb[27:0])});
    end

    // Mixed sweep over every opcode and operand bit pattern
    for (int it = 0; it < 600; it++) begin
      logic [31:0] a, b;
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      doOp(a[6:4], a, b, k);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule